// File: doc/BRIEF.md
# Channel Event Interrupt Queue

This block turns status changes on a bank of per-channel tone-disable lines into a queue of channel numbers for a host processor. Every channel produces one event when its status line rises and a second event when it falls. Each event is stored as the number of the channel that produced it, and the queue keeps these entries in arrival order until the host reads them.

Events that occur in the same cycle on several channels are first held in a per-channel pending bit. They then move into the queue one per cycle, lowest channel number first. An active-low interrupt line tells the host that entries are waiting. Each read returns the oldest entry and forces the line high for one cycle. If entries remain, the line then drops low again, so the host sees one low pulse per event.

If the queue is full, a new event is dropped and a sticky overflow output is set. A read of an empty queue returns zero.

Top module: `evq_top`

## Requirements
- R1: A rising edge on `tone_stat[i]` produces exactly one queue entry whose value is `i`, written as an unsigned binary channel number `CH_W` bits wide (5 bits for 32 channels).
- R2: A falling edge on `tone_stat[i]` produces another entry with value `i`, separate from the entry made by the rising edge.
- R3: When several channels change in the same cycle, their entries go into the queue one per cycle in ascending channel order.
- R4: Entries stay in the queue until read and are returned oldest first. The queue holds up to `DEPTH` entries (64 by default), which is every channel both rising and falling.
- R5: With the queue empty and no read in progress, a status change sampled at clock edge t drives `irq_n` low after edge t+1.
- R6: A cycle with `rd_en` high pops the oldest entry. The entry appears on `rd_data` after that clock edge, and `irq_n` is high for the cycle that follows.
- R7: In a cycle with `rd_en` low, `irq_n` after the next edge is low if at least one entry remains, and high if the queue is empty.
- R8: A read of an empty queue puts zero on `rd_data` and leaves the queue empty.
- R9: An event that arrives while the queue holds `DEPTH` entries and no read is popping is dropped. The stored entries are left unchanged, and `ovf` goes high and stays high until reset.
- R10: After reset, `rd_data` is zero, `irq_n` is high, `ovf` is low and the queue is empty.
- R11: An event on a channel that is waiting behind other pending channels is held and enqueued later. A lower-numbered channel that becomes pending afterwards goes ahead of the higher-numbered channels still waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_stat | input | N_CH | Per-channel tone-disable status |
| rd_en | input | 1 | Host read strobe; pops one entry per high cycle |
| rd_data | output | CH_W | Channel number of the entry popped by the last read |
| irq_n | output | 1 | Active-low interrupt request |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The edge detector and the pending latch both register their inputs, so a status change made before edge t sets a pending bit at t. The channel reaches the queue and pulls `irq_n` low at edge t+1, or later if it waits its turn. `rd_data` and the high `irq_n` pulse are due one edge after the read strobe, and the return of `irq_n` to its queue-state level is due one edge after that. The bench drives inputs just after a falling edge and samples at the next falling edge or later, so every check lands in the cycle where the result is due. Queue contents are checked only after the pending bits have had enough cycles to drain into the queue.

// File: rtl/evq_pkg.sv
package evq_pkg;

  localparam int unsigned MAX_CH = 64;

  // Index of the lowest set bit among the first n bits, or -1 if none.
  function automatic int lowest_one(input logic [MAX_CH-1:0] v, input int unsigned n);
    int r;
    r = -1;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (i < int'(n) && v[i]) r = i;
    end
    return r;
  endfunction

  // Number of set bits among the first n bits.
  function automatic int unsigned ones_count(input logic [MAX_CH-1:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int i = 0; i < MAX_CH; i++) begin
      if (i < int'(n) && v[i]) c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/evq_edge_latch.sv
module evq_edge_latch #(
  parameter int unsigned N_CH = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] stat,
  input  logic [N_CH-1:0] grant,
  output logic [N_CH-1:0] pend
);
  logic [N_CH-1:0] prev_q;
  logic [N_CH-1:0] edge_seen;

  assign edge_seen = stat ^ prev_q;

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q[g] <= 1'b0;
          pend[g]   <= 1'b0;
        end else begin
          prev_q[g] <= stat[g];
          pend[g]   <= (pend[g] & ~grant[g]) | edge_seen[g];
        end
      end
    end
  endgenerate

  AST_EDGE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_seen) |=> (|pend)); // R1
  AST_GRANT_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant & ~pend)) == 1'b0); // R11

endmodule

// File: rtl/evq_prio.sv
module evq_prio
  import evq_pkg::*;
#(
  parameter int unsigned N_CH = 32,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0] req,
  output logic [N_CH-1:0] grant,
  output logic [CH_W-1:0] idx,
  output logic            valid
);
  int pick;

  always_comb begin
    pick  = lowest_one(MAX_CH'(req), N_CH);
    valid = (pick >= 0);
    idx   = valid ? CH_W'(pick) : '0;
    grant = '0;
    if (valid) grant[idx] = 1'b1;
  end

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R3
    if (valid) begin
      AST_NO_LOWER_REQ: assert (ones_count(MAX_CH'(req & (grant - 1'b1)), N_CH) == 0); // R3
    end
  end

endmodule

// File: rtl/evq_fifo.sv
module evq_fifo #(
  parameter int unsigned W     = 5,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         empty_nxt,
  output logic         drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt, cnt_nxt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (cnt == '0);
  assign full      = (cnt == (AW+1)'(DEPTH));
  assign do_pop    = pop && !empty;
  assign do_push   = push && (!full || do_pop);
  assign drop      = push && !do_push;
  assign head      = mem[rptr];
  assign cnt_nxt   = cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
  assign empty_nxt = (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      cnt <= cnt_nxt;
    end
  end

  AST_FULL_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == $past(cnt) && rptr == $past(rptr))); // R9
  AST_EMPTY_POP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty); // R8
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full) |=> (cnt == $past(cnt) + 1'b1)); // R4

endmodule

// File: rtl/evq_top.sv
module evq_top #(
  parameter int unsigned N_CH  = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] tone_stat,
  input  logic            rd_en,
  output logic [CH_W-1:0] rd_data,
  output logic            irq_n,
  output logic            ovf
);
  logic [N_CH-1:0] pend, grant;
  logic [CH_W-1:0] pick_idx, head;
  logic            pick_vld;
  logic            q_empty, q_full, q_empty_nxt, q_drop;

  evq_edge_latch #(.N_CH(N_CH)) u_latch (
    .clk(clk), .rst_n(rst_n), .stat(tone_stat), .grant(grant), .pend(pend)
  );

  evq_prio #(.N_CH(N_CH)) u_prio (
    .req(pend), .grant(grant), .idx(pick_idx), .valid(pick_vld)
  );

  evq_fifo #(.W(CH_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(pick_vld), .wdata(pick_idx), .pop(rd_en),
    .head(head), .empty(q_empty), .full(q_full), .empty_nxt(q_empty_nxt),
    .drop(q_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      irq_n   <= 1'b1;
      ovf     <= 1'b0;
    end else begin
      if (rd_en) rd_data <= q_empty ? '0 : head;
      irq_n <= rd_en ? 1'b1 : q_empty_nxt;
      ovf   <= ovf | q_drop;
    end
  end

  AST_IRQ_HIGH_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> irq_n); // R6
  AST_IRQ_LOW_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !q_empty) |=> !irq_n); // R7
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && q_empty) |=> (rd_data == '0)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R9
  AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_vld && q_full && !rd_en) |=> ovf); // R9

endmodule

// File: tb/sim_evq_top.sv
module sim_evq_top;
  localparam int unsigned N  = 32;
  localparam int unsigned D  = 64;
  localparam int unsigned CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  stat = '0;
  logic          rd_en = 1'b0;
  logic [CW-1:0] rd_data;
  logic          irq_n, ovf;

  int n_chk = 0;
  int n_bad = 0;
  int expq[$];
  bit exp_ovf = 0;

  always #5 clk = ~clk;

  evq_top #(.N_CH(N), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .tone_stat(stat), .rd_en(rd_en),
    .rd_data(rd_data), .irq_n(irq_n), .ovf(ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_push(input int ch);
    if (expq.size() >= D) exp_ovf = 1;
    else expq.push_back(ch);
  endtask

  // Apply a new status vector; model events in ascending channel order.
  task automatic apply(input logic [N-1:0] v);
    logic [N-1:0] d;
    d = v ^ stat;
    for (int i = 0; i < N; i++) if (d[i]) model_push(i);
    stat = v;
    repeat (N + 4) @(negedge clk);
  endtask

  task automatic read_one(input string req);
    int e;
    e = (expq.size() > 0) ? expq.pop_front() : 0;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check({req, " rd_data"}, int'(rd_data), e);
    check("R6 irq_n high after read", int'(irq_n), 1);
    @(negedge clk);
    check("R7 irq_n follows queue", int'(irq_n), (expq.size() == 0) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 rd_data", int'(rd_data), 0);
    check("R10 irq_n", int'(irq_n), 1);
    check("R10 ovf", int'(ovf), 0);
    rst_n = 1'b1;
    @(negedge clk);

    read_one("R8 empty read");

    // R5 latency: one channel rises, queue empty
    stat[7] = 1'b1;
    model_push(7);
    @(negedge clk);
    check("R5 irq_n after first edge", int'(irq_n), 1);
    @(negedge clk);
    check("R5 irq_n low after second edge", int'(irq_n), 0);
    repeat (3) @(negedge clk);
    read_one("R1 ch7 rise");
    apply(stat & ~(N'(1) << 7));
    check("R7 irq pending", int'(irq_n), 0);
    read_one("R2 ch7 fall");

    // Sweep every channel: rise then fall, one read each
    for (int c = 0; c < N; c++) begin
      apply(stat | (N'(1) << c));
      read_one("R1 sweep rise");
      apply(stat & ~(N'(1) << c));
      read_one("R2 sweep fall");
    end

    // Several patterns of simultaneous changes, drained in ascending order
    apply(32'hA5A5_0F0F);
    apply(32'h0000_FFFF);
    while (expq.size() > 0) read_one("R3 simultaneous");
    apply('0);
    while (expq.size() > 0) read_one("R4 fifo order");

    // R11: ch0 becomes pending one cycle after ch1..31 went pending
    stat = 32'hFFFF_FFFE;
    @(negedge clk);
    stat[0] = 1'b1;
    expq.push_back(1);
    expq.push_back(0);
    for (int i = 2; i < N; i++) expq.push_back(i);
    repeat (N + 4) @(negedge clk);
    for (int k = 0; k < 3; k++) read_one("R11 late low channel");
    while (expq.size() > 0) read_one("R11 remaining");

    // Fill to depth, then overflow by one
    apply('0);
    while (expq.size() > 0) read_one("R4 drain");
    apply('1);
    apply('0);
    check("R4 no ovf at depth", int'(ovf), 0);
    apply(N'(1) << 5);
    check("R9 ovf set", int'(ovf), int'(exp_ovf));
    check("R9 queue kept", expq.size(), D);
    while (expq.size() > 0) read_one("R9 contents unchanged");
    read_one("R8 empty after drain");
    check("R9 ovf sticky", int'(ovf), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule